// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Host Controller

This block drives the host side of a three-wire serial EEPROM link, the kind where the host owns chip select, the serial clock and the data-in line and reads back a single data-out line. Commands arrive one at a time on a valid/ready request channel. Each command reads a word, writes a word, erases a word, enables programming or disables programming. The block turns the command into a serial frame: a start bit, a two-bit opcode, the address and, for writes, the data word. It shifts the frame out with the serial clock derived from the system clock by a fixed divider.

A read clocks back one extra bit beyond the word, because the device sends a leading zero before the data. The block discards that zero and returns the word on the response channel. After a write or erase the block releases chip select so that the device starts its internal programming cycle. It then holds chip select low for a minimum number of system clocks, raises it again and watches data-out each clock until the device signals completion. A timeout bounds that wait. Programming commands are refused locally with an error until an enable command has been sent since reset.

The response channel is valid/ready as well. A response stays on its pins, unchanged, until the consumer takes it. The block accepts no new command while a command is in flight or a response is waiting, so back-pressure on the response side stalls the request side.

Top module: `mw_host`

## Requirements
- R1: A frame is sent with chip select high and consists of a start bit of 1, a two-bit opcode, ADDR_W address bits MSB first and, for writes only, DATA_W data bits MSB first. The command codes on `cmd_op` are 0 read (opcode 10), 1 write (opcode 01), 2 erase (opcode 11), 3 enable (opcode 00, address field 11 followed by zeros), and 4 to 7 disable (opcode 00, address field all zeros).
- R2: The serial clock idles low, toggles only while chip select is high, and each of its half periods lasts DIV system clocks. The data-in line changes only when the serial clock falls, so it is stable at every rising edge.
- R3: A read clocks DATA_W+1 bits in from data-out, sampled on falling serial clock edges. The first bit is dropped and the remaining DATA_W bits form the returned word, MSB first.
- R4: After every frame and after every status poll, chip select stays low for at least CSL_CYC system clocks before it rises again.
- R5: After a write or erase, the block raises chip select once the low time has elapsed and samples data-out each clock. It completes with `rsp_err` = 0 only once data-out reads high.
- R6: If data-out stays low for POLL_LIMIT clocks of polling, the block drops chip select and completes the command with `rsp_err` = 1.
- R7: Programming is enabled by an enable command and disabled by a disable command. While programming is disabled, a write or erase completes with `rsp_err` = 1 and sends no frame. Reads work regardless of the enable state.
- R8: `cmd_ready` is high only while no command is in flight and no response is waiting. A command is accepted on a clock where `cmd_valid` and `cmd_ready` are both high.
- R9: While `rsp_valid` is high and `rsp_ready` is low, `rsp_valid`, `rsp_data` and `rsp_err` hold their values. `rsp_data` is 0 for every command other than a successful read.
- R10: After reset, chip select, serial clock and data-in are low, `cmd_ready` is high, `rsp_valid` is low and programming is disabled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command request valid |
| cmd_ready | output | 1 | Block can take a command |
| cmd_op | input | 3 | Command code (see R1) |
| cmd_addr | input | ADDR_W | Word address |
| cmd_wdata | input | DATA_W | Word to write |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_data | output | DATA_W | Word returned by a read |
| rsp_err | output | 1 | Command refused or timed out |
| mw_cs | output | 1 | Chip select to the EEPROM |
| mw_sck | output | 1 | Serial clock to the EEPROM |
| mw_di | output | 1 | Serial data to the EEPROM |
| mw_do | input | 1 | Serial data and ready status from the EEPROM |

## Verification
The bench puts words with their top bit set into the device model. A controller that kept the leading zero would return each word shifted right by one, with its top bit cleared. It issues writes and erases before any enable and after a disable, and checks that no start bit reaches the model. A block that ignored the enable state would overwrite a word that a later read shows unchanged. A device model that stays busy forever exposes a missing timeout as a hang. A programming response that arrives before the model's busy time exposes a fixed-delay wait in place of polling. Holding back the response channel and measuring every chip-select low gap and serial half period catch dropped responses, early re-selection and a wrong divider.

// File: rtl/mw_pkg.sv
package mw_pkg;
  typedef enum logic [2:0] {
    OP_READ  = 3'd0,
    OP_WRITE = 3'd1,
    OP_ERASE = 3'd2,
    OP_WREN  = 3'd3,
    OP_WRDIS = 3'd4
  } host_op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SHIFT,
    ST_RDATA,
    ST_GAP,
    ST_POLL,
    ST_RESP
  } host_state_e;

  // two-bit opcode sent after the start bit (R1)
  function automatic logic [1:0] opcode_of(input logic [2:0] op);
    case (op)
      OP_READ:  opcode_of = 2'b10;
      OP_WRITE: opcode_of = 2'b01;
      OP_ERASE: opcode_of = 2'b11;
      default:  opcode_of = 2'b00;
    endcase
  endfunction
endpackage

// File: rtl/mw_sck_div.sv
module mw_sck_div #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic sck,
  output logic fall
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

  logic [CW-1:0] cnt;
  logic          wrap;

  assign wrap = run && (cnt == CW'(DIV - 1));
  assign fall = wrap && sck;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      sck <= 1'b0;
    end else if (!run) begin
      cnt <= '0;
      sck <= 1'b0;
    end else if (wrap) begin
      cnt <= '0;
      sck <= ~sck;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/mw_shreg.sv
module mw_shreg #(
  parameter int W     = 8,
  parameter int OUT_W = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [W-1:0]     din,
  input  logic             shift,
  input  logic             sin,
  output logic [OUT_W-1:0] q
);
  logic [W-1:0] r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     r <= '0;
    else if (load)  r <= din;
    else if (shift) r <= {r[W-2:0], sin};
  end

  assign q = r[W-1 -: OUT_W];
endmodule

// File: rtl/mw_host.sv
module mw_host
  import mw_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int ADDR_W     = 6,
  parameter int DIV        = 4,
  parameter int CSL_CYC    = 13,
  parameter int POLL_LIMIT = 4096
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [2:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [DATA_W-1:0] cmd_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_data,
  output logic              rsp_err,
  output logic              mw_cs,
  output logic              mw_sck,
  output logic              mw_di,
  input  logic              mw_do
);
  localparam int HDR_W   = 3 + ADDR_W;
  localparam int TX_W    = HDR_W + DATA_W;
  localparam int CNT_W   = $clog2(TX_W + 1);
  localparam int TMR_MAX = (CSL_CYC > POLL_LIMIT) ? CSL_CYC : POLL_LIMIT;
  localparam int TMR_W   = $clog2(TMR_MAX + 1);

  host_state_e       state;
  logic [CNT_W-1:0]  cnt;
  logic [TMR_W-1:0]  tmr;
  logic [2:0]        op_q;
  logic              cs_q, is_rd, is_prog, wen, err_q;
  logic              sck_fall, accept, is_wr_in, is_prog_in;
  logic [ADDR_W-1:0] addr_f;
  logic [TX_W-1:0]   frame;
  logic              tx_msb;
  logic              rx_shift;

  assign accept     = (state == ST_IDLE) && cmd_valid;
  assign is_wr_in   = (cmd_op == OP_WRITE);
  assign is_prog_in = is_wr_in || (cmd_op == OP_ERASE);

  always_comb begin
    if (cmd_op == OP_WREN)        addr_f = {2'b11, {(ADDR_W-2){1'b0}}};
    else if (cmd_op >= OP_WRDIS)  addr_f = '0;
    else                          addr_f = cmd_addr;
  end
  assign frame = {1'b1, opcode_of(cmd_op), addr_f, cmd_wdata};

  mw_sck_div #(.DIV(DIV)) u_div (
    .clk  (clk),
    .rst_n(rst_n),
    .run  ((state == ST_SHIFT) || (state == ST_RDATA)),
    .sck  (mw_sck),
    .fall (sck_fall)
  );

  mw_shreg #(.W(TX_W), .OUT_W(1)) u_tx (
    .clk  (clk),
    .rst_n(rst_n),
    .load (accept),
    .din  (frame),
    .shift(sck_fall && (state == ST_SHIFT)),
    .sin  (1'b0),
    .q    (tx_msb)
  );

  // first read sample (the leading zero) is taken at the last header fall
  assign rx_shift = sck_fall &&
                    ((state == ST_RDATA) ||
                     ((state == ST_SHIFT) && is_rd && (cnt == CNT_W'(1))));

  mw_shreg #(.W(DATA_W), .OUT_W(DATA_W)) u_rx (
    .clk  (clk),
    .rst_n(rst_n),
    .load (accept),
    .din  ('0),
    .shift(rx_shift),
    .sin  (mw_do),
    .q    (rsp_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      tmr     <= '0;
      op_q    <= '0;
      cs_q    <= 1'b0;
      is_rd   <= 1'b0;
      is_prog <= 1'b0;
      wen     <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (cmd_valid) begin
          op_q    <= cmd_op;
          err_q   <= 1'b0;
          is_rd   <= (cmd_op == OP_READ);
          is_prog <= is_prog_in;
          if (is_prog_in && !wen) begin
            err_q <= 1'b1;
            state <= ST_RESP;
          end else begin
            cs_q  <= 1'b1;
            cnt   <= is_wr_in ? CNT_W'(TX_W) : CNT_W'(HDR_W);
            state <= ST_SHIFT;
          end
        end
        ST_SHIFT: if (sck_fall) begin
          if (cnt == CNT_W'(1)) begin
            if (is_rd) begin
              cnt   <= CNT_W'(DATA_W);
              state <= ST_RDATA;
            end else begin
              cs_q  <= 1'b0;
              tmr   <= '0;
              state <= ST_GAP;
              if (!is_prog) wen <= (op_q == OP_WREN);
            end
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_RDATA: if (sck_fall) begin
          if (cnt == CNT_W'(1)) begin
            cs_q  <= 1'b0;
            tmr   <= '0;
            state <= ST_GAP;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_GAP: begin
          if (tmr == TMR_W'(CSL_CYC - 1)) begin
            tmr <= '0;
            if (is_prog) begin
              cs_q  <= 1'b1;
              state <= ST_POLL;
            end else begin
              state <= ST_RESP;
            end
          end else begin
            tmr <= tmr + 1'b1;
          end
        end
        ST_POLL: begin
          if (mw_do || (tmr == TMR_W'(POLL_LIMIT - 1))) begin
            err_q   <= !mw_do;
            is_prog <= 1'b0;
            cs_q    <= 1'b0;
            tmr     <= '0;
            state   <= ST_GAP;
          end else begin
            tmr <= tmr + 1'b1;
          end
        end
        ST_RESP: if (rsp_ready) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign cmd_ready = (state == ST_IDLE);
  assign rsp_valid = (state == ST_RESP);
  assign rsp_err   = err_q;
  assign mw_cs     = cs_q;
  assign mw_di     = (state == ST_SHIFT) ? tx_msb : 1'b0;
endmodule

// File: rtl/mw_host_chk.sv
module mw_host_chk #(
  parameter int DATA_W  = 16,
  parameter int CSL_CYC = 13
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_ready,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [DATA_W-1:0] rsp_data,
  input logic              rsp_err,
  input logic              mw_cs,
  input logic              mw_sck,
  input logic              mw_di
);
  int low_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            low_run <= CSL_CYC;
    else if (mw_cs)        low_run <= 0;
    else if (low_run < CSL_CYC) low_run <= low_run + 1;
  end

  a_r2_sck_needs_cs: assert property (@(posedge clk) disable iff (!rst_n)
    mw_sck |-> mw_cs);

  a_r2_di_steady_at_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mw_sck) |-> $stable(mw_di));

  a_r4_cs_low_gap: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mw_cs) |-> (low_run >= CSL_CYC));

  a_r8_no_cmd_while_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !cmd_ready);

  a_r9_rsp_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data) && $stable(rsp_err)));
endmodule

bind mw_host mw_host_chk #(.DATA_W(DATA_W), .CSL_CYC(CSL_CYC)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cmd_ready(cmd_ready),
  .rsp_valid(rsp_valid),
  .rsp_ready(rsp_ready),
  .rsp_data (rsp_data),
  .rsp_err  (rsp_err),
  .mw_cs    (mw_cs),
  .mw_sck   (mw_sck),
  .mw_di    (mw_di)
);

// File: tb/mw_host_test.sv
`timescale 1ns/1ps
module mw_host_test;
  localparam int DIV   = 2;
  localparam int CSL   = 13;
  localparam int PLIM  = 300;
  localparam int BUSY  = 40;
  localparam int NVEC  = 14;

  logic        clk = 0, rst_n = 0;
  logic        cmd_valid = 0, rsp_ready = 0;
  logic [2:0]  cmd_op = 0;
  logic [5:0]  cmd_addr = 0;
  logic [15:0] cmd_wdata = 0;
  logic        cmd_ready, rsp_valid, rsp_err, mw_cs, mw_sck, mw_di;
  logic [15:0] rsp_data;
  logic        dev_do = 1'b1;

  int checks = 0, errors = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  mw_host #(.DATA_W(16), .ADDR_W(6), .DIV(DIV), .CSL_CYC(CSL), .POLL_LIMIT(PLIM)) uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data), .rsp_err(rsp_err),
    .mw_cs(mw_cs), .mw_sck(mw_sck), .mw_di(mw_di), .mw_do(dev_do));

  // ---------------- EEPROM model ----------------
  logic [15:0] mem [64];
  logic [23:0] dv_sh;
  logic [1:0]  dv_op, last_op;
  logic [5:0]  dv_addr, last_addr;
  logic [15:0] last_wd;
  logic        dv_act = 0, dv_wen = 0, dv_pend = 0, rd_mode = 0, rd_bit = 0;
  logic        stuck = 0, sck_d = 0, cs_d = 0;
  int dv_bits, rd_idx, busy = 0, dv_frames = 0, cyc_n = 0;
  int cs_fall_at = -100000, min_gap = 1000000, last_tog = -1, bad_half = 0, nhalf = 0;

  initial for (int i = 0; i < 64; i++) mem[i] = 16'h8000 | 16'(i);

  always @(posedge clk) begin
    cyc_n++;
    if (mw_sck && !sck_d && mw_cs) begin
      if (!dv_act) begin
        if (mw_di) begin dv_act = 1; dv_bits = 0; dv_sh = 0; dv_frames++; end
      end else if (rd_mode) begin
        rd_bit = (rd_idx < 16) ? mem[dv_addr][15-rd_idx] : 1'b0;
        rd_idx++;
      end else begin
        dv_sh = {dv_sh[22:0], mw_di};
        dv_bits++;
        if (dv_bits == 8) begin
          dv_op = dv_sh[7:6]; dv_addr = dv_sh[5:0];
          last_op = dv_op; last_addr = dv_addr;
          case (dv_op)
            2'b10: begin rd_mode = 1; rd_idx = 0; rd_bit = 0; end
            2'b11: dv_pend = 1;
            2'b00: begin
              if (dv_sh[5:4] == 2'b11) dv_wen = 1;
              else if (dv_sh[5:4] == 2'b00) dv_wen = 0;
            end
            default: ;
          endcase
        end
        if (dv_bits == 24 && dv_op == 2'b01) begin dv_pend = 1; last_wd = dv_sh[15:0]; end
      end
    end
    if (!mw_cs && cs_d) begin
      if (dv_pend && dv_wen) begin
        mem[dv_addr] = (dv_op == 2'b11) ? 16'hffff : last_wd;
        busy = BUSY;
      end
      dv_pend = 0; dv_act = 0; rd_mode = 0; cs_fall_at = cyc_n;
    end else if (busy > 0) busy--;
    if (mw_cs && !cs_d) begin
      if (cyc_n - cs_fall_at < min_gap) min_gap = cyc_n - cs_fall_at;
      last_tog = -1;
    end
    if (mw_sck != sck_d) begin
      if (last_tog >= 0 && cyc_n - last_tog != DIV) bad_half++;
      nhalf++;
      last_tog = cyc_n;
    end
    dev_do <= rd_mode ? rd_bit : !(busy > 0 || stuck);
    sck_d = mw_sck; cs_d = mw_cs;
  end

  // ---------------- helpers ----------------
  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic do_cmd(input logic [2:0] op, input logic [5:0] a, input logic [15:0] d,
                        output logic [15:0] rd, output logic re, output int cyc);
    @(negedge clk);
    cmd_op = op; cmd_addr = a; cmd_wdata = d; cmd_valid = 1;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 0; cyc = 1;
    while (!rsp_valid) begin @(negedge clk); cyc++; end
    rd = rsp_data; re = rsp_err;
    rsp_ready = 1;
    @(negedge clk);
    rsp_ready = 0;
  endtask

  function automatic logic [1:0] exp_opc(input logic [2:0] op);
    case (op) 3'd0: return 2'b10; 3'd1: return 2'b01; 3'd2: return 2'b11; default: return 2'b00; endcase
  endfunction

  function automatic logic [5:0] exp_addr(input logic [2:0] op, input logic [5:0] a);
    if (op == 3'd3) return 6'b110000;
    if (op >= 3'd4) return 6'b000000;
    return a;
  endfunction

  // {op, addr, wdata, expected data, expected err}
  localparam logic [41:0] VEC [NVEC] = '{
    {3'd0, 6'd2,  16'h0000, 16'h8002, 1'b0},  // R3 read before enable
    {3'd1, 6'd5,  16'ha5c3, 16'h0000, 1'b1},  // R7 write refused
    {3'd2, 6'd5,  16'h0000, 16'h0000, 1'b1},  // R7 erase refused
    {3'd3, 6'd0,  16'h0000, 16'h0000, 1'b0},  // R7 enable
    {3'd1, 6'd5,  16'ha5c3, 16'h0000, 1'b0},  // R5 write
    {3'd0, 6'd5,  16'h0000, 16'ha5c3, 1'b0},  // R3 read back
    {3'd2, 6'd5,  16'h0000, 16'h0000, 1'b0},  // R5 erase
    {3'd0, 6'd5,  16'h0000, 16'hffff, 1'b0},  // R3 erased word
    {3'd1, 6'd63, 16'h0001, 16'h0000, 1'b0},  // R1 top address
    {3'd0, 6'd63, 16'h0000, 16'h0001, 1'b0},  // R3
    {3'd4, 6'd9,  16'h0000, 16'h0000, 1'b0},  // R7 disable
    {3'd1, 6'd63, 16'h1234, 16'h0000, 1'b1},  // R7 refused after disable
    {3'd0, 6'd63, 16'h0000, 16'h0001, 1'b0},  // R7 word untouched
    {3'd0, 6'd0,  16'h0000, 16'h8000, 1'b0}   // R3
  };

  // ---------------- watchdog ----------------
  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  initial begin
    logic [15:0] rd, held;
    logic re;
    int cyc, fr, bad;

    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10 cs", mw_cs, 0);
    chk("R10 sck", mw_sck, 0);
    chk("R10 di", mw_di, 0);
    chk("R10 cmd_ready", cmd_ready, 1);
    chk("R10 rsp_valid", rsp_valid, 0);
    rst_n = 1;
    @(negedge clk);

    for (int i = 0; i < NVEC; i++) begin
      logic [41:0] v;
      v = VEC[i];
      fr = dv_frames;
      do_cmd(v[41:39], v[38:33], v[32:17], rd, re, cyc);
      chk($sformatf("R3/R9 data vec%0d", i), rd, v[16:1]);
      chk($sformatf("R5/R7 err vec%0d", i), re, v[0]);
      if (v[0]) begin
        chk($sformatf("R7 no frame vec%0d", i), dv_frames, fr);
      end else begin
        chk($sformatf("R1 one frame vec%0d", i), dv_frames, fr + 1);
        chk($sformatf("R1 opcode vec%0d", i), last_op, exp_opc(v[41:39]));
        chk($sformatf("R1 address vec%0d", i), last_addr, exp_addr(v[41:39], v[38:33]));
        if (v[41:39] == 3'd1) chk($sformatf("R1 wdata vec%0d", i), last_wd, v[32:17]);
        if (v[41:39] == 3'd1 || v[41:39] == 3'd2)
          chk($sformatf("R5 waits for ready vec%0d", i), (cyc >= BUSY), 1);
      end
    end

    // R8 / R9 back-pressure: response held, second command stalled
    @(negedge clk);
    cmd_op = 3'd0; cmd_addr = 6'd5; cmd_valid = 1;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_addr = 6'd63;               // second command waits behind the first
    while (!rsp_valid) @(negedge clk);
    held = rsp_data; fr = dv_frames; bad = 0;
    repeat (30) begin
      @(negedge clk);
      if (!rsp_valid || rsp_data !== held || cmd_ready) bad++;
    end
    chk("R9 response held", bad, 0);
    chk("R9 held data", held, 16'hffff);
    chk("R8 no frame while response waits", dv_frames, fr);
    rsp_ready = 1; @(negedge clk); rsp_ready = 0;
    while (cmd_ready) @(negedge clk);   // second command accepted
    cmd_valid = 0;
    while (!rsp_valid) @(negedge clk);
    chk("R8 queued read data", rsp_data, 16'h0001);
    rsp_ready = 1; @(negedge clk); rsp_ready = 0;

    // R6 poll timeout with a device that never finishes
    do_cmd(3'd3, 0, 0, rd, re, cyc);
    stuck = 1;
    do_cmd(3'd1, 6'd7, 16'h5a5a, rd, re, cyc);
    chk("R6 timeout error", re, 1);
    chk("R6 waited full limit", (cyc >= PLIM), 1);
    chk("R6 cs released", mw_cs, 0);
    stuck = 0;
    do_cmd(3'd0, 6'd7, 0, rd, re, cyc);
    chk("R6 recovery read", rd, 16'h5a5a);

    // R10 reset clears the programming enable
    @(negedge clk); rst_n = 0;
    repeat (2) @(negedge clk); rst_n = 1;
    fr = dv_frames;
    do_cmd(3'd1, 6'd7, 16'h0f0f, rd, re, cyc);
    chk("R10 write refused after reset", re, 1);
    chk("R10 no frame after reset", dv_frames, fr);

    // R2 / R4 timing gathered over the whole run
    chk("R2 half periods equal DIV", bad_half, 0);
    chk("R2 clock seen", (nhalf > 0), 1);
    chk("R4 minimum cs low gap", (min_gap >= CSL), 1);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule